// File: doc/BRIEF.md
# Transactional Commit and Conflict Unit

This block is the per-core part of a scheme where every instruction runs inside a transaction. While a transaction runs, each accepted load marks its data-cache line in a read set, and each accepted store goes into a small write buffer instead of memory. At the end of the transaction the core asks for a single shared commit bus. Once it holds the bus, it places every buffered address and value on that bus, one entry per cycle, and then releases the bus.

Every other core watches the same bus through its snoop input. When a broadcast address falls in a line that the watching core has read, that core aborts. It pulses its abort and checkpoint-restore outputs, and in the same cycle it empties both its read set and its write buffer.

If the write buffer fills and a store needs a new slot, the unit stalls the core and takes the commit bus. It drains the buffer and keeps the bus until the transaction ends. During that time later stores go straight onto the bus and the transaction cannot be aborted.

Top module: `txn_commit_unit`

## Requirements
- R1: An accepted load sets the read bit of the line given by address bits [5:2] (defaults: 2 offset bits, 16 lines). Only those index bits identify a line, so addresses that differ only above bit 5 share one bit. A later snoop whose bits [5:2] match a set bit causes an abort.
- R2: A snoop whose line has no read bit set causes no abort.
- R3: On a conflict, abort_o and restore_o are both high for exactly one cycle, the cycle after the snoop is sampled. At the same edge the read set and the write buffer are emptied, and any pending bus request is withdrawn.
- R4: Stores stay in the write buffer and do not appear on the broadcast bus before commit. A store to an address already buffered overwrites that entry's data and takes no new slot.
- R5: tx_end with a non-empty buffer raises cbus_req, which stays high until cbus_gnt is seen. stall_o is high while the unit waits.
- R6: In the cycle after the grant is seen, the buffered entries are broadcast, one per cycle with cb_valid high, in the order their addresses were first stored. done_o pulses and cbus_req drops in the cycle after the last entry.
- R7: tx_end with an empty buffer pulses done_o in the next cycle and does not request the bus.
- R8: A commit clears every read bit in one cycle, so a later snoop to a previously read line does not abort.
- R9: Snoops that arrive while the unit is broadcasting its own commit are ignored.
- R10: A store to a new address while the buffer is full is an overflow. The unit stalls and requests the bus. After the grant it drains every entry, then holds the bus and stalls no longer. From then on each store appears on the broadcast bus in the same cycle, snoops cause no abort, and tx_end pulses done_o and releases the bus.
- R11: A store to an already-buffered address while the buffer is full coalesces and does not overflow: no stall and no bus request.
- R12: While waiting for the grant, either for a normal commit or after an overflow, a conflicting snoop still aborts the transaction.
- R13: After reset no request, broadcast, stall, abort or done is active, the read set is empty and the write buffer is empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mem_ld | input | 1 | Transactional load request |
| mem_st | input | 1 | Transactional store request |
| mem_addr | input | ADDR_W | Load/store byte address |
| mem_wdata | input | DATA_W | Store data |
| stall_o | output | 1 | Core must hold its request or wait |
| tx_end | input | 1 | Core reached the end of the transaction |
| done_o | output | 1 | One-cycle pulse: transaction committed |
| cbus_req | output | 1 | Commit bus request |
| cbus_gnt | input | 1 | Commit bus grant |
| cb_valid | output | 1 | Own broadcast entry is valid |
| cb_addr | output | ADDR_W | Own broadcast address |
| cb_data | output | DATA_W | Own broadcast data |
| snp_valid | input | 1 | Another core's broadcast is valid |
| snp_addr | input | ADDR_W | Another core's broadcast address |
| abort_o | output | 1 | One-cycle pulse: transaction aborted |
| restore_o | output | 1 | One-cycle pulse: restore registers from the checkpoint |

## Verification
The embedded properties assume a well-behaved bus and core. A grant arrives only while this unit requests and stays high until the request drops. No foreign snoop arrives while this unit holds the bus. tx_end never coincides with a load or store. A stalled store is held until it is accepted. The bench drives the grant only after seeing cbus_req and keeps it until done_o. It issues snoops only in cycles when it is not granting this unit, except the deliberate snoops that test that they are ignored. It never combines tx_end with a memory operation.

// File: rtl/cc_pkg.sv
// Package: shared types of the transactional commit unit.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package cc_pkg;
    // Controller phases of one core's transaction life cycle.
    typedef enum logic [2:0] {
        ST_RUN       = 3'd0,
        ST_REQ       = 3'd1,
        ST_BCAST     = 3'd2,
        ST_OVF_REQ   = 3'd3,
        ST_OVF_DRAIN = 3'd4,
        ST_OVF_HOLD  = 3'd5
    } cc_state_e;
endpackage

// File: rtl/cc_read_set.sv
// Read-set tracker: one bit per data-cache line, indexed by address bits
// [OFF_W +: IDX_W]. No tag is kept, so aliasing lines share a bit (conservative).
// Assumes OFF_W >= 1 and OFF_W + IDX_W < ADDR_W. Clear wins over set.
module cc_read_set #(
    parameter int ADDR_W = 16,
    parameter int OFF_W  = 2,
    parameter int IDX_W  = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      set_en,
    input  logic [ADDR_W-1:0]         set_addr,
    input  logic                      clr,
    input  logic [ADDR_W-1:0]         qry_addr,
    output logic                      qry_hit,
    output logic [(1<<IDX_W)-1:0]     bits_o
);
    localparam int NUM_LINES = 1 << IDX_W;

    logic [IDX_W-1:0] set_idx;
    logic [IDX_W-1:0] qry_idx;
    logic             unused_addr_bits;

    assign set_idx = set_addr[OFF_W +: IDX_W];
    assign qry_idx = qry_addr[OFF_W +: IDX_W];
    assign unused_addr_bits = ^{set_addr[OFF_W-1:0], set_addr[ADDR_W-1:OFF_W+IDX_W],
                                qry_addr[OFF_W-1:0], qry_addr[ADDR_W-1:OFF_W+IDX_W]};

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        // Per-line read bit: set by a load to this line, cleared in bulk.
        always_ff @(posedge clk) begin
            if (!rst_n)
                bits_o[g] <= 1'b0;
            else if (clr)
                bits_o[g] <= 1'b0;
            else if (set_en && (set_idx == IDX_W'(g)))
                bits_o[g] <= 1'b1;
        end
    end

    assign qry_hit = bits_o[qry_idx];

    // R1
    rs_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((bits_o & $past(bits_o)) == $past(bits_o)));
endmodule

// File: rtl/cc_write_buf.sv
// Write buffer: holds speculative stores in arrival order until commit.
// A store to an address already held overwrites that entry (coalescing).
// Assumes DEPTH >= 2. Clear wins over write; a miss while full is dropped
// (the controller never issues one).
module cc_write_buf #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int DEPTH  = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clr,
    input  logic                         wr_en,
    input  logic [ADDR_W-1:0]            wr_addr,
    input  logic [DATA_W-1:0]            wr_data,
    output logic                         hit,
    output logic                         full,
    output logic [$clog2(DEPTH+1)-1:0]   cnt_o,
    input  logic [$clog2(DEPTH)-1:0]     rd_ptr,
    output logic [ADDR_W-1:0]            rd_addr,
    output logic [DATA_W-1:0]            rd_data
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [ADDR_W-1:0] addr_q [DEPTH];
    logic [DATA_W-1:0] data_q [DEPTH];
    logic [CNT_W-1:0]  cnt_q;
    logic [DEPTH-1:0]  match;
    logic [PTR_W-1:0]  hit_idx;
    logic [PTR_W-1:0]  tail;

    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign match[g] = (CNT_W'(g) < cnt_q) && (addr_q[g] == wr_addr);
    end

    // Encode which valid entry holds the store address.
    always_comb begin
        hit_idx = '0;
        for (int i = 0; i < DEPTH; i++)
            if (match[i]) hit_idx = PTR_W'(i);
    end

    assign hit   = |match;
    assign full  = (cnt_q == CNT_W'(DEPTH));
    assign tail  = cnt_q[PTR_W-1:0];
    assign cnt_o = cnt_q;

    // Occupancy: grows on a fresh store, zeroed by clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clr)
            cnt_q <= '0;
        else if (wr_en && !hit && !full)
            cnt_q <= cnt_q + CNT_W'(1);
    end

    // Entry storage: overwrite on hit, append at the tail otherwise.
    always_ff @(posedge clk) begin
        if (wr_en && !clr) begin
            if (hit)
                data_q[hit_idx] <= wr_data;
            else if (!full) begin
                addr_q[tail] <= wr_addr;
                data_q[tail] <= wr_data;
            end
        end
    end

    assign rd_addr = addr_q[rd_ptr];
    assign rd_data = data_q[rd_ptr];

    // R4
    wb_cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(DEPTH));
    // R4
    wb_coalesce_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && hit && !clr) |=> (cnt_q == $past(cnt_q)));
endmodule

// File: rtl/cc_commit_fsm.sv
// Commit controller: sequences run, bus request, broadcast, abort and the
// overflow path that holds the bus to the end of the transaction.
// Assumes the grant stays high while requested and tx_end never coincides
// with a load or store.
module cc_commit_fsm
    import cc_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         mem_ld,
    input  logic                         mem_st,
    input  logic                         tx_end,
    input  logic                         gnt,
    input  logic                         snp_conflict,
    input  logic                         wb_full,
    input  logic                         wb_hit,
    input  logic [$clog2(DEPTH+1)-1:0]   wb_cnt,
    output cc_state_e                    state_o,
    output logic [$clog2(DEPTH)-1:0]     ptr_o,
    output logic                         stall_o,
    output logic                         req_o,
    output logic                         wb_wr_o,
    output logic                         wb_clr_o,
    output logic                         rs_set_o,
    output logic                         rs_clr_o,
    output logic                         wt_o,
    output logic                         abort_o,
    output logic                         done_o
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    cc_state_e        state_q, state_d;
    logic [PTR_W-1:0] ptr_q, ptr_d;
    logic             abort_evt, commit_evt, ovf_evt;
    logic             last_bcast, last_drain, full_miss, sending;
    logic             abort_q, done_q;

    assign full_miss  = mem_st && wb_full && !wb_hit;
    assign sending    = (state_q == ST_BCAST) || (state_q == ST_OVF_DRAIN);
    assign abort_evt  = snp_conflict && ((state_q == ST_RUN) || (state_q == ST_REQ) ||
                                         (state_q == ST_OVF_REQ));
    assign ovf_evt    = (state_q == ST_RUN) && full_miss && !abort_evt;
    assign last_bcast = (state_q == ST_BCAST) && ((CNT_W'(ptr_q) + CNT_W'(1)) == wb_cnt);
    assign last_drain = (state_q == ST_OVF_DRAIN) && (ptr_q == PTR_W'(DEPTH - 1));
    assign commit_evt = ((state_q == ST_RUN) && tx_end && (wb_cnt == '0) && !abort_evt) ||
                        last_bcast || ((state_q == ST_OVF_HOLD) && tx_end);

    assign stall_o  = ((state_q == ST_RUN) && full_miss) || (state_q == ST_REQ) ||
                      sending || (state_q == ST_OVF_REQ);
    assign req_o    = (state_q != ST_RUN);
    assign wb_wr_o  = (state_q == ST_RUN) && mem_st && !stall_o;
    assign rs_set_o = mem_ld && !stall_o &&
                      ((state_q == ST_RUN) || (state_q == ST_OVF_HOLD));
    assign rs_clr_o = abort_evt || commit_evt;
    assign wb_clr_o = abort_evt || commit_evt || last_drain;
    assign wt_o     = (state_q == ST_OVF_HOLD) && mem_st;
    assign ptr_d    = sending ? ptr_q + PTR_W'(1) : '0;

    // Next-phase selection; abort has priority in every abortable phase.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (abort_evt)                     state_d = ST_RUN;
                else if (ovf_evt)                  state_d = ST_OVF_REQ;
                else if (tx_end && wb_cnt != '0)   state_d = ST_REQ;
            end
            ST_REQ: begin
                if (abort_evt)                     state_d = ST_RUN;
                else if (gnt)                      state_d = ST_BCAST;
            end
            ST_BCAST:     if (last_bcast)          state_d = ST_RUN;
            ST_OVF_REQ: begin
                if (abort_evt)                     state_d = ST_RUN;
                else if (gnt)                      state_d = ST_OVF_DRAIN;
            end
            ST_OVF_DRAIN: if (last_drain)          state_d = ST_OVF_HOLD;
            ST_OVF_HOLD:  if (tx_end)              state_d = ST_RUN;
            default:                               state_d = ST_RUN;
        endcase
    end

    // Phase, broadcast pointer and registered event pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            ptr_q   <= '0;
            abort_q <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            ptr_q   <= ptr_d;
            abort_q <= abort_evt;
            done_q  <= commit_evt;
        end
    end

    assign state_o = state_q;
    assign ptr_o   = ptr_q;
    assign abort_o = abort_q;
    assign done_o  = done_q;

    // R3
    abort_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort_q |=> !abort_q);
    // R5
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && !gnt && !snp_conflict) |=> req_o);
    // R6
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);
endmodule

// File: rtl/txn_commit_unit.sv
// Top of the per-core commit-time conflict unit: ties the read set, the
// write buffer and the commit controller to the core, the commit bus and
// the snoop input. Assumes one bus owner at a time and a held grant.
module txn_commit_unit
    import cc_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 32,
    parameter int OFF_W    = 2,
    parameter int IDX_W    = 4,
    parameter int WB_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mem_ld,
    input  logic              mem_st,
    input  logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_wdata,
    output logic              stall_o,
    input  logic              tx_end,
    output logic              done_o,
    output logic              cbus_req,
    input  logic              cbus_gnt,
    output logic              cb_valid,
    output logic [ADDR_W-1:0] cb_addr,
    output logic [DATA_W-1:0] cb_data,
    input  logic              snp_valid,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              abort_o,
    output logic              restore_o
);
    localparam int NUM_LINES = 1 << IDX_W;
    localparam int PTR_W     = $clog2(WB_DEPTH);
    localparam int CNT_W     = $clog2(WB_DEPTH + 1);

    cc_state_e              state;
    logic [PTR_W-1:0]       ptr;
    logic                   wb_wr, wb_clr, rs_set, rs_clr, wt;
    logic                   rs_hit, wb_hit, wb_full, abort_pulse;
    logic [CNT_W-1:0]       wb_cnt;
    logic [NUM_LINES-1:0]   rbits;
    logic [ADDR_W-1:0]      wb_rd_addr;
    logic [DATA_W-1:0]      wb_rd_data;
    logic                   draining;

    cc_read_set #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_rset (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_en   (rs_set),
        .set_addr (mem_addr),
        .clr      (rs_clr),
        .qry_addr (snp_addr),
        .qry_hit  (rs_hit),
        .bits_o   (rbits)
    );

    cc_write_buf #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(WB_DEPTH)) u_wbuf (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (wb_clr),
        .wr_en   (wb_wr),
        .wr_addr (mem_addr),
        .wr_data (mem_wdata),
        .hit     (wb_hit),
        .full    (wb_full),
        .cnt_o   (wb_cnt),
        .rd_ptr  (ptr),
        .rd_addr (wb_rd_addr),
        .rd_data (wb_rd_data)
    );

    cc_commit_fsm #(.DEPTH(WB_DEPTH)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .mem_ld       (mem_ld),
        .mem_st       (mem_st),
        .tx_end       (tx_end),
        .gnt          (cbus_gnt),
        .snp_conflict (snp_valid && rs_hit),
        .wb_full      (wb_full),
        .wb_hit       (wb_hit),
        .wb_cnt       (wb_cnt),
        .state_o      (state),
        .ptr_o        (ptr),
        .stall_o      (stall_o),
        .req_o        (cbus_req),
        .wb_wr_o      (wb_wr),
        .wb_clr_o     (wb_clr),
        .rs_set_o     (rs_set),
        .rs_clr_o     (rs_clr),
        .wt_o         (wt),
        .abort_o      (abort_pulse),
        .done_o       (done_o)
    );

    assign draining  = (state == ST_BCAST) || (state == ST_OVF_DRAIN);
    assign cb_valid  = draining || wt;
    assign cb_addr   = wt ? mem_addr  : wb_rd_addr;
    assign cb_data   = wt ? mem_wdata : wb_rd_data;
    assign abort_o   = abort_pulse;
    assign restore_o = abort_pulse;

    // R3
    abort_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort_o |-> ((rbits == '0) && (wb_cnt == '0) && !cbus_req));
    // R8
    done_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (rbits == '0));
    // R9
    no_abort_after_send_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cb_valid |=> !abort_o);
    // R10
    cb_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cb_valid |-> cbus_gnt);
    // R5
    stall_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cbus_req && !cbus_gnt) |-> stall_o);
endmodule

// File: tb/tb_txn_commit_unit.sv
module tb_txn_commit_unit;
    localparam int AW = 16;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n, mem_ld, mem_st, tx_end, cbus_gnt, snp_valid;
    logic [AW-1:0] mem_addr, snp_addr;
    logic [DW-1:0] mem_wdata;
    logic          stall_o, done_o, cbus_req, cb_valid, abort_o, restore_o;
    logic [AW-1:0] cb_addr;
    logic [DW-1:0] cb_data;
    int            checks = 0;
    int            errors = 0;

    always #5 clk = ~clk;

    txn_commit_unit dut (
        .clk(clk), .rst_n(rst_n), .mem_ld(mem_ld), .mem_st(mem_st),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .stall_o(stall_o),
        .tx_end(tx_end), .done_o(done_o), .cbus_req(cbus_req), .cbus_gnt(cbus_gnt),
        .cb_valid(cb_valid), .cb_addr(cb_addr), .cb_data(cb_data),
        .snp_valid(snp_valid), .snp_addr(snp_addr), .abort_o(abort_o),
        .restore_o(restore_o)
    );

    // {load address, snoop address, abort expected}; line index is bits [5:2]
    localparam logic [32:0] VEC [0:7] = '{
        {16'h0010, 16'h0010, 1'b1},
        {16'h0010, 16'h0013, 1'b1},
        {16'h0010, 16'h0014, 1'b0},
        {16'h0040, 16'h0000, 1'b1},
        {16'h003C, 16'h003C, 1'b1},
        {16'h003C, 16'h0038, 1'b0},
        {16'h1234, 16'h0034, 1'b1},
        {16'h0004, 16'h0008, 1'b0}
    };

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_load(input logic [AW-1:0] a);
        mem_ld = 1'b1; mem_addr = a;
        tick();
        mem_ld = 1'b0;
    endtask

    task automatic do_store(input logic [AW-1:0] a, input logic [DW-1:0] d);
        mem_st = 1'b1; mem_addr = a; mem_wdata = d;
        #2;
        check("R4 no broadcast before commit", 32'(cb_valid), 32'd0);
        tick();
        mem_st = 1'b0;
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        rst_n = 1'b0; mem_ld = 1'b0; mem_st = 1'b0; tx_end = 1'b0; cbus_gnt = 1'b0;
        snp_valid = 1'b0; mem_addr = '0; snp_addr = '0; mem_wdata = '0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R13 reset state
        check("R13 req after reset", 32'(cbus_req), 32'd0);
        check("R13 cb_valid after reset", 32'(cb_valid), 32'd0);
        check("R13 stall after reset", 32'(stall_o), 32'd0);
        check("R13 abort after reset", 32'(abort_o), 32'd0);
        check("R13 done after reset", 32'(done_o), 32'd0);
        snp_valid = 1'b1; snp_addr = 16'h0010;
        tick();
        snp_valid = 1'b0;
        check("R13 empty read set", 32'(abort_o), 32'd0);
        tx_end = 1'b1;
        tick();
        tx_end = 1'b0;
        check("R13 empty buffer commit", 32'(done_o), 32'd1);
        check("R13 no request", 32'(cbus_req), 32'd0);

        // Table walk: R1 set/match, R2 miss, R3 pulse, R7 read-only commit
        for (int i = 0; i < 8; i++) begin
            do_load(VEC[i][32:17]);
            snp_valid = 1'b1; snp_addr = VEC[i][16:1];
            tick();
            snp_valid = 1'b0;
            check(VEC[i][0] ? "R1 abort on read line" : "R2 no abort on other line",
                  32'(abort_o), 32'(VEC[i][0]));
            check("R3 restore with abort", 32'(restore_o), 32'(VEC[i][0]));
            tick();
            check("R3 abort one cycle", 32'(abort_o), 32'd0);
            tx_end = 1'b1;
            tick();
            tx_end = 1'b0;
            check("R7 read-only done", 32'(done_o), 32'd1);
            check("R7 no bus request", 32'(cbus_req), 32'd0);
            tick();
        end

        // Normal commit with coalescing: R4 R5 R6 R9 R8
        do_load(16'h0200);
        do_store(16'h0100, 32'hA);
        do_store(16'h0104, 32'hB);
        do_store(16'h0100, 32'hC);
        tx_end = 1'b1;
        tick();
        tx_end = 1'b0;
        check("R5 request raised", 32'(cbus_req), 32'd1);
        check("R5 stall while waiting", 32'(stall_o), 32'd1);
        tick();
        check("R5 request held", 32'(cbus_req), 32'd1);
        check("R4 nothing sent before grant", 32'(cb_valid), 32'd0);
        cbus_gnt = 1'b1;
        tick();
        check("R6 first entry valid", 32'(cb_valid), 32'd1);
        check("R6 first entry addr", 32'(cb_addr), 32'h0100);
        check("R4 coalesced data", cb_data, 32'hC);
        snp_valid = 1'b1; snp_addr = 16'h0200;
        tick();
        snp_valid = 1'b0;
        check("R6 second entry addr", 32'(cb_addr), 32'h0104);
        check("R6 second entry data", cb_data, 32'hB);
        check("R9 snoop ignored while sending", 32'(abort_o), 32'd0);
        tick();
        check("R6 done after last", 32'(done_o), 32'd1);
        check("R6 request dropped", 32'(cbus_req), 32'd0);
        check("R4 only two entries", 32'(cb_valid), 32'd0);
        cbus_gnt = 1'b0;
        snp_valid = 1'b1; snp_addr = 16'h0200;
        tick();
        snp_valid = 1'b0;
        check("R8 read bits cleared by commit", 32'(abort_o), 32'd0);

        // Abort while waiting for grant: R12 R3
        do_load(16'h0300);
        do_store(16'h0400, 32'h77);
        tx_end = 1'b1;
        tick();
        tx_end = 1'b0;
        check("R12 waiting", 32'(cbus_req), 32'd1);
        snp_valid = 1'b1; snp_addr = 16'h0300;
        tick();
        snp_valid = 1'b0;
        check("R12 abort while waiting", 32'(abort_o), 32'd1);
        check("R3 restore pulse", 32'(restore_o), 32'd1);
        check("R3 request withdrawn", 32'(cbus_req), 32'd0);
        tick();
        check("R3 abort one cycle", 32'(abort_o), 32'd0);
        tx_end = 1'b1;
        tick();
        tx_end = 1'b0;
        check("R3 buffer emptied", 32'(done_o), 32'd1);
        check("R3 no request after abort", 32'(cbus_req), 32'd0);

        // Overflow path: R11 R10
        do_load(16'h0500);
        do_store(16'h0010, 32'd1);
        do_store(16'h0014, 32'd2);
        do_store(16'h0018, 32'd3);
        do_store(16'h001C, 32'd4);
        mem_st = 1'b1; mem_addr = 16'h0014; mem_wdata = 32'd9;
        #2;
        check("R11 full hit no stall", 32'(stall_o), 32'd0);
        check("R11 full hit no request", 32'(cbus_req), 32'd0);
        tick();
        mem_addr = 16'h0020; mem_wdata = 32'd5;
        #2;
        check("R10 overflow stalls", 32'(stall_o), 32'd1);
        tick();
        check("R10 overflow requests", 32'(cbus_req), 32'd1);
        check("R10 stall while waiting", 32'(stall_o), 32'd1);
        cbus_gnt = 1'b1;
        tick();
        check("R10 drain entry 0", 32'(cb_addr), 32'h0010);
        check("R10 drain valid", 32'(cb_valid), 32'd1);
        tick();
        check("R10 drain entry 1 addr", 32'(cb_addr), 32'h0014);
        check("R11 coalesced data", cb_data, 32'd9);
        tick();
        check("R10 drain entry 2", 32'(cb_addr), 32'h0018);
        tick();
        check("R10 drain entry 3", cb_data, 32'd4);
        tick();
        check("R10 stall released", 32'(stall_o), 32'd0);
        check("R10 write-through addr", 32'(cb_addr), 32'h0020);
        check("R10 write-through data", cb_data, 32'd5);
        snp_valid = 1'b1; snp_addr = 16'h0500;
        tick();
        mem_st = 1'b0; snp_valid = 1'b0;
        check("R10 no abort while holding", 32'(abort_o), 32'd0);
        check("R10 bus held", 32'(cbus_req), 32'd1);
        mem_st = 1'b1; mem_addr = 16'h0024; mem_wdata = 32'd6;
        #2;
        check("R10 second write-through", cb_data, 32'd6);
        tick();
        mem_st = 1'b0;
        tx_end = 1'b1;
        tick();
        tx_end = 1'b0;
        check("R10 done at end", 32'(done_o), 32'd1);
        check("R10 bus released", 32'(cbus_req), 32'd0);
        cbus_gnt = 1'b0;
        tick();

        summary();
        $finish;
    end
endmodule